// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps a 32-bit effective address to a physical page through a small set of block mapping register pairs. Each pair holds an upper word (block base, block length, two valid bits) and a lower word (real block base). Instruction fetches and data accesses each have their own set of pairs, and the access class picks the set. A request is answered one clock later with a hit flag, the page-aligned physical address, the page-aligned effective address and the 12-bit page offset.

When the translate-enable bit for the access class is clear, the unit passes the address through unchanged and always reports a hit. When translation is on and no pair matches, it reports a miss so that a page-table walker can take over. A write port loads either word of any pair. A write that names a set or pair that does not exist changes nothing and raises an error pulse.

Top module: `bat_xlate_unit`

## Requirements
- R1: With `side_i`=0 (instruction) and `itrans_en_i`=0, or with `side_i`=1 (data) and `dtrans_en_i`=0, the response has `hit_o`=1 and `phys_page_o` equal to `ea_i` with bits [11:0] cleared. The enable bit of the other class has no effect.
- R2: Upper word bit 1 is the supervisor valid bit and bit 0 is the user valid bit. `priv_i`=0 (supervisor) tests bit 1 and `priv_i`=1 (user) tests bit 0. A pair whose tested bit is clear never matches.
- R3: Upper word bits [31:17] hold the effective block base and bits [12:2] hold an 11-bit block length L. A pair matches when the base equals `ea_i` AND (~L shifted left by 17). A set bit in L widens the block by that address bit.
- R4: When several pairs match, the lowest index supplies the translation.
- R5: On a hit with translation on, `phys_page_o` = (lower word with bits [16:0] cleared) + ((`ea_i` with bits [11:0] cleared) − block base).
- R6: On each response, `offset_o` equals `ea_i[11:0]` and `ea_page_o` equals `ea_i` with bits [11:0] cleared.
- R7: Writes with `wr_arr_i`=0 load the instruction set, and writes with `wr_arr_i`=1 load the data set. A lookup reads only the set named by `side_i`.
- R8: With translation on and no matching pair, `hit_o`=0 while `rsp_valid_o`=1.
- R9: A write with `wr_idx_i` ≥ 4 or `wr_arr_i` ≥ 2 changes no register. `wr_err_o` is 1 in the following cycle and 0 after every other cycle.
- R10: A request in cycle n gives `rsp_valid_o`=1 in cycle n+1. Without a request, `rsp_valid_o` and `hit_o` are 0 and the other outputs hold. A write (`wr_hi_i`=1 selects the upper word, 0 the lower word) becomes visible to lookups in the next cycle; a lookup in the same cycle still sees the old value.
- R11: After reset, all outputs are 0 and all registers are clear, so a translated lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Lookup request |
| side_i | input | 1 | Access class: 0 instruction, 1 data |
| ea_i | input | 32 | Effective address |
| priv_i | input | 1 | Privilege: 0 supervisor, 1 user |
| itrans_en_i | input | 1 | Instruction translate enable |
| dtrans_en_i | input | 1 | Data translate enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_arr_i | input | 2 | Register set select: 0 instruction, 1 data |
| wr_idx_i | input | 3 | Pair index |
| wr_hi_i | input | 1 | 1 upper word, 0 lower word |
| wr_data_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid |
| hit_o | output | 1 | Translation found |
| phys_page_o | output | 32 | Page-aligned physical address |
| offset_o | output | 12 | Page offset |
| ea_page_o | output | 32 | Page-aligned effective address |
| wr_err_o | output | 1 | Rejected write in previous cycle |

## Verification
The assertions check on every cycle the pass-through mapping when translation is off, the response timing, the offset and effective-page outputs, and that a rejected write raises the error and leaves both register sets unchanged. Which valid bit is tested, how the block length shapes the mask, priority among overlapping pairs, the offset arithmetic and the separation of the two sets depend on what was programmed earlier. Only the bench's scenarios show these, by comparing against its reference model on every clock.

// File: rtl/bat_xlate_pkg.sv
package bat_xlate_pkg;
  typedef enum logic {SIDE_INSN = 1'b0, SIDE_DATA = 1'b1} side_e;
  localparam logic [1:0] ARR_INSN = 2'd0;
  localparam logic [1:0] ARR_DATA = 2'd1;
  localparam int unsigned NUM_SIDES = 2;
endpackage

// File: rtl/bat_regfile.sv
module bat_regfile #(
  parameter int unsigned NUM_PAIRS = 4,
  parameter int unsigned AW        = 32,
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned SEL_W     = 2
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   wr_en_i,
  input  logic [SEL_W-1:0]                       wr_arr_i,
  input  logic [IDX_W-1:0]                       wr_idx_i,
  input  logic                                   wr_hi_i,
  input  logic [AW-1:0]                          wr_data_i,
  output logic [1:0][NUM_PAIRS-1:0][AW-1:0]      up_o,
  output logic [1:0][NUM_PAIRS-1:0][AW-1:0]      lo_o,
  output logic                                   wr_err_o
);
  import bat_xlate_pkg::*;

  localparam logic [IDX_W:0] PAIR_LIM = (IDX_W+1)'(NUM_PAIRS);

  logic [1:0][NUM_PAIRS-1:0][AW-1:0] up_q, lo_q;
  logic arr_ok, idx_ok, wr_ok, wr_bad;
  logic err_q;

  assign arr_ok = (wr_arr_i == SEL_W'(ARR_INSN)) || (wr_arr_i == SEL_W'(ARR_DATA));
  assign idx_ok = {1'b0, wr_idx_i} < PAIR_LIM;
  assign wr_ok  = wr_en_i && arr_ok && idx_ok;
  assign wr_bad = wr_en_i && !(arr_ok && idx_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q  <= '0;
      lo_q  <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= wr_bad;
      if (wr_ok) begin
        for (int s = 0; s < NUM_SIDES; s++) begin
          for (int i = 0; i < NUM_PAIRS; i++) begin
            if (wr_arr_i[0] == s[0] && wr_idx_i == IDX_W'(i)) begin
              if (wr_hi_i) up_q[s][i] <= wr_data_i;
              else         lo_q[s][i] <= wr_data_i;
            end
          end
        end
      end
    end
  end

  assign up_o     = up_q;
  assign lo_o     = lo_q;
  assign wr_err_o = err_q;

  assert_bad_wr_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (!arr_ok || !idx_ok)) |=> wr_err_o);
  assert_bad_wr_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (!arr_ok || !idx_ok)) |=> ($stable(up_q) && $stable(lo_q)));
  assert_good_wr_noerr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !wr_err_o);
endmodule

// File: rtl/bat_entry_match.sv
module bat_entry_match #(
  parameter int unsigned AW        = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned BL_W      = 11,
  parameter int unsigned BL_POS    = 2,
  parameter int unsigned BASE_LSB  = 17,
  parameter int unsigned VS_BIT    = 1,
  parameter int unsigned VU_BIT    = 0
) (
  input  logic [AW-1:0] up_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] ea_i,
  input  logic          priv_i,
  output logic          match_o,
  output logic [AW-1:0] page_o
);
  localparam logic [AW-1:0] BASE_MASK = ~((AW'(1) << BASE_LSB) - AW'(1));
  localparam logic [AW-1:0] PAGE_MASK = ~((AW'(1) << PAGE_BITS) - AW'(1));

  logic [BL_W-1:0] blen;
  logic [AW-1:0]   cmp_mask, base, ea_pg;
  logic            vld;

  assign blen     = up_i[BL_POS +: BL_W];
  assign cmp_mask = ~{{(AW-BL_W){1'b0}}, blen} << BASE_LSB;
  assign base     = up_i & BASE_MASK;
  assign ea_pg    = ea_i & PAGE_MASK;
  // user mode tests the user valid bit, supervisor the supervisor bit
  assign vld      = priv_i ? up_i[VU_BIT] : up_i[VS_BIT];
  assign match_o  = vld && (base == (ea_i & cmp_mask));
  assign page_o   = (lo_i & BASE_MASK) + (ea_pg - base);
endmodule

// File: rtl/bat_prio_select.sv
module bat_prio_select #(
  parameter int unsigned NUM_PAIRS = 4,
  parameter int unsigned AW        = 32
) (
  input  logic [NUM_PAIRS-1:0]          match_i,
  input  logic [NUM_PAIRS-1:0][AW-1:0]  page_i,
  output logic                          hit_o,
  output logic [AW-1:0]                 page_o
);
  // scan from the top so the lowest index wins
  always_comb begin
    hit_o  = 1'b0;
    page_o = '0;
    for (int i = NUM_PAIRS - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        hit_o  = 1'b1;
        page_o = page_i[i];
      end
    end
  end
endmodule

// File: rtl/bat_xlate_unit.sv
module bat_xlate_unit #(
  parameter int unsigned NUM_PAIRS = 4,
  parameter int unsigned AW        = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned BL_W      = 11,
  parameter int unsigned BASE_LSB  = 17,
  parameter int unsigned IDX_W     = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 side_i,
  input  logic [AW-1:0]        ea_i,
  input  logic                 priv_i,
  input  logic                 itrans_en_i,
  input  logic                 dtrans_en_i,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_arr_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic                 wr_hi_i,
  input  logic [AW-1:0]        wr_data_i,
  output logic                 rsp_valid_o,
  output logic                 hit_o,
  output logic [AW-1:0]        phys_page_o,
  output logic [PAGE_BITS-1:0] offset_o,
  output logic [AW-1:0]        ea_page_o,
  output logic                 wr_err_o
);
  import bat_xlate_pkg::*;

  localparam logic [AW-1:0] PAGE_MASK = ~((AW'(1) << PAGE_BITS) - AW'(1));

  logic [1:0][NUM_PAIRS-1:0][AW-1:0] up_w, lo_w;
  logic [NUM_PAIRS-1:0]              match_w;
  logic [NUM_PAIRS-1:0][AW-1:0]      page_w;
  logic                              sel_hit;
  logic [AW-1:0]                     sel_page, ea_pg, page_c;
  logic                              xlate_en, hit_c;
  side_e                             side_s;

  bat_regfile #(
    .NUM_PAIRS(NUM_PAIRS), .AW(AW), .IDX_W(IDX_W), .SEL_W(2)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_arr_i (wr_arr_i),
    .wr_idx_i (wr_idx_i),
    .wr_hi_i  (wr_hi_i),
    .wr_data_i(wr_data_i),
    .up_o     (up_w),
    .lo_o     (lo_w),
    .wr_err_o (wr_err_o)
  );

  assign side_s = side_e'(side_i);

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    bat_entry_match #(
      .AW(AW), .PAGE_BITS(PAGE_BITS), .BL_W(BL_W), .BL_POS(2),
      .BASE_LSB(BASE_LSB), .VS_BIT(1), .VU_BIT(0)
    ) u_match (
      .up_i   (up_w[side_s][g]),
      .lo_i   (lo_w[side_s][g]),
      .ea_i   (ea_i),
      .priv_i (priv_i),
      .match_o(match_w[g]),
      .page_o (page_w[g])
    );
  end

  bat_prio_select #(.NUM_PAIRS(NUM_PAIRS), .AW(AW)) u_sel (
    .match_i(match_w),
    .page_i (page_w),
    .hit_o  (sel_hit),
    .page_o (sel_page)
  );

  assign xlate_en = (side_s == SIDE_DATA) ? dtrans_en_i : itrans_en_i;
  assign ea_pg    = ea_i & PAGE_MASK;
  assign hit_c    = !xlate_en || sel_hit;
  assign page_c   = xlate_en ? sel_page : ea_pg;

  logic                 vld_q, hit_q;
  logic [AW-1:0]        page_q, eap_q;
  logic [PAGE_BITS-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      hit_q  <= 1'b0;
      page_q <= '0;
      eap_q  <= '0;
      off_q  <= '0;
    end else begin
      vld_q <= req_i;
      hit_q <= req_i && hit_c;
      if (req_i) begin
        page_q <= page_c;
        eap_q  <= ea_pg;
        off_q  <= ea_i[PAGE_BITS-1:0];
      end
    end
  end

  assign rsp_valid_o = vld_q;
  assign hit_o       = hit_q;
  assign phys_page_o = page_q;
  assign ea_page_o   = eap_q;
  assign offset_o    = off_q;

  assert_bypass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ((side_i && !dtrans_en_i) || (!side_i && !itrans_en_i)))
      |=> (hit_o && phys_page_o == ($past(ea_i) & PAGE_MASK)));
  assert_req_rsp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!rsp_valid_o && !hit_o && $stable(phys_page_o)));
  assert_offset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (offset_o == $past(ea_i[PAGE_BITS-1:0])
               && ea_page_o == ($past(ea_i) & PAGE_MASK)));
endmodule

// File: tb/bat_xlate_unit_test.sv
`timescale 1ns/1ps
module bat_xlate_unit_test;
  logic        clk, rst_n;
  logic        req, side, priv, ien, den, wen, whi;
  logic [31:0] ea, wdata;
  logic [1:0]  warr;
  logic [2:0]  widx;
  logic        rsp_valid, hit, werr;
  logic [31:0] ppage, eapage;
  logic [11:0] off;

  bat_xlate_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .side_i(side), .ea_i(ea),
    .priv_i(priv), .itrans_en_i(ien), .dtrans_en_i(den), .wr_en_i(wen),
    .wr_arr_i(warr), .wr_idx_i(widx), .wr_hi_i(whi), .wr_data_i(wdata),
    .rsp_valid_o(rsp_valid), .hit_o(hit), .phys_page_o(ppage),
    .offset_o(off), .ea_page_o(eapage), .wr_err_o(werr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] ref_up [2][4];
  logic [31:0] ref_lo [2][4];
  logic        e_vld, e_hit, e_err;
  logic [31:0] e_page, e_eap;
  logic [11:0] e_off;
  string       cur_tag;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired (R10) act=running exp=finished");
    finish_run();
  end

  function automatic void model_lookup(input logic sd, input logic [31:0] a,
      input logic pv, input logic en, output logic h, output logic [31:0] pg);
    h = 0; pg = 0;
    if (!en) begin h = 1; pg = a & 32'hFFFF_F000; return; end
    for (int i = 0; i < 4; i++) begin
      logic [31:0] u, msk, bse;
      logic        v;
      u   = ref_up[sd][i];
      v   = pv ? u[0] : u[1];
      msk = ~((u >> 2) & 32'h7FF) << 17;
      bse = u & 32'hFFFE_0000;
      if (v && bse == (a & msk)) begin
        h  = 1;
        pg = (ref_lo[sd][i] & 32'hFFFE_0000) + ((a & 32'hFFFF_F000) - bse);
        return;
      end
    end
  endfunction

  task automatic compare();
    total++;
    if (rsp_valid !== e_vld || hit !== e_hit || werr !== e_err ||
        ppage !== e_page || eapage !== e_eap || off !== e_off) begin
      bad++;
      $display("FAIL %s act vld=%b hit=%b err=%b page=%h eap=%h off=%h exp vld=%b hit=%b err=%b page=%h eap=%h off=%h",
               cur_tag, rsp_valid, hit, werr, ppage, eapage, off,
               e_vld, e_hit, e_err, e_page, e_eap, e_off);
    end
  endtask

  task automatic cyc(input string t, input logic rq, input logic sd,
      input logic [31:0] a, input logic pv, input logic ie, input logic de,
      input logic we, input logic [1:0] wa, input logic [2:0] wi,
      input logic wh, input logic [31:0] wd);
    logic h;
    logic [31:0] pg;
    @(negedge clk);
    compare();
    req = rq; side = sd; ea = a; priv = pv; ien = ie; den = de;
    wen = we; warr = wa; widx = wi; whi = wh; wdata = wd;
    model_lookup(sd, a, pv, sd ? de : ie, h, pg);
    e_vld = rq;
    e_hit = rq & h;
    if (rq) begin e_page = pg; e_eap = a & 32'hFFFF_F000; e_off = a[11:0]; end
    e_err = we && (wa > 2'd1 || wi > 3'd3);
    if (we && wa <= 2'd1 && wi <= 3'd3) begin
      if (wh) ref_up[wa[0]][wi[1:0]] = wd;
      else    ref_lo[wa[0]][wi[1:0]] = wd;
    end
    cur_tag = t;
  endtask

  task automatic lk(input string t, input logic sd, input logic [31:0] a,
      input logic pv, input logic ie, input logic de);
    cyc(t, 1, sd, a, pv, ie, de, 0, 2'd0, 3'd0, 0, 32'h0);
  endtask

  task automatic wr(input string t, input logic [1:0] wa, input logic [2:0] wi,
      input logic wh, input logic [31:0] wd);
    cyc(t, 0, 0, 32'h0, 0, 1, 1, 1, wa, wi, wh, wd);
  endtask

  initial begin
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 4; i++) begin ref_up[s][i] = 0; ref_lo[s][i] = 0; end
    rst_n = 0; req = 0; side = 0; ea = 0; priv = 0; ien = 0; den = 0;
    wen = 0; warr = 0; widx = 0; whi = 0; wdata = 0;
    e_vld = 0; e_hit = 0; e_err = 0; e_page = 0; e_eap = 0; e_off = 0;
    cur_tag = "R11 reset";
    repeat (3) begin @(negedge clk); compare(); end
    rst_n = 1;
    cyc("R11 idle after reset", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    lk("R11 cleared regs miss", 0, 32'h1000_5ABC, 0, 1, 1);
    lk("R8 data side miss", 1, 32'h0000_0000, 1, 1, 1);
    // R1 pass-through per class
    lk("R1 insn bypass", 0, 32'h1234_5678, 0, 0, 1);
    lk("R1 data bypass", 1, 32'hFFFF_FFFF, 1, 1, 0);
    // program I0 (supervisor only), D0 (both)
    wr("R7 load I0 up", 2'd0, 3'd0, 1, 32'h1000_0002);
    wr("R7 load I0 lo", 2'd0, 3'd0, 0, 32'h8000_0000);
    wr("R7 load D0 up", 2'd1, 3'd0, 1, 32'h1000_0003);
    wr("R7 load D0 lo", 2'd1, 3'd0, 0, 32'h4000_0000);
    lk("R2 supervisor hit I0", 0, 32'h1000_5ABC, 0, 1, 1);
    lk("R2 user skip I0", 0, 32'h1000_5ABC, 1, 1, 1);
    lk("R7 data set used", 1, 32'h1000_5ABC, 1, 1, 1);
    lk("R1 other enable ignored", 1, 32'h1000_5ABC, 1, 0, 1);
    // R3 block length 2 MB
    wr("R3 load I1 up", 2'd0, 3'd1, 1, 32'h2000_003F);
    wr("R3 load I1 lo", 2'd0, 3'd1, 0, 32'h6000_0000);
    lk("R3 inside widened block", 0, 32'h201F_F123, 1, 1, 1);
    lk("R3 just outside block", 0, 32'h2020_0000, 1, 1, 1);
    lk("R5 offset from base", 0, 32'h2001_2FFF, 0, 1, 1);
    // R4 overlapping pairs
    wr("R4 load I2 up", 2'd0, 3'd2, 1, 32'h3000_0003);
    wr("R4 load I2 lo", 2'd0, 3'd2, 0, 32'hA000_0000);
    wr("R4 load I3 up", 2'd0, 3'd3, 1, 32'h3000_1FFF);
    wr("R4 load I3 lo", 2'd0, 3'd3, 0, 32'hB000_0000);
    lk("R4 lower index wins", 0, 32'h3000_1000, 0, 1, 1);
    lk("R4 only upper pair", 0, 32'h3002_0000, 0, 1, 1);
    lk("R5 full-size block", 0, 32'h3ABC_D321, 1, 1, 1);
    // R9 rejected writes
    wr("R9 index out of range", 2'd0, 3'd5, 1, 32'h1000_0000);
    wr("R9 unknown set", 2'd2, 3'd0, 1, 32'h0000_0000);
    wr("R9 unknown set 3", 2'd3, 3'd0, 0, 32'h0000_0000);
    lk("R9 I0 unchanged", 0, 32'h1000_5ABC, 0, 1, 1);
    lk("R9 D0 unchanged", 1, 32'h1000_5ABC, 0, 1, 1);
    // R10 write visibility
    cyc("R10 same-cycle old value", 1, 0, 32'h1000_5ABC, 0, 1, 1,
        1, 2'd0, 3'd0, 1, 32'h1000_0000);
    lk("R10 new value next cycle", 0, 32'h1000_5ABC, 0, 1, 1);
    cyc("R10 idle holds", 0, 0, 32'hDEAD_BEEF, 0, 1, 1, 0, 0, 0, 0, 0);
    wr("R10 restore I0", 2'd0, 3'd0, 1, 32'h1000_0002);
    lk("R6 offset and page", 0, 32'h1000_0FFF, 0, 1, 1);
    // mixed traffic, model compared on every clock
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      logic [2:0]  r;
      r = 3'($urandom_range(0, 4));
      case (r)
        3'd0: a = 32'h1000_0000;
        3'd1: a = 32'h2000_0000;
        3'd2: a = 32'h3000_0000;
        3'd3: a = 32'h4000_0000;
        default: a = 32'h3ABC_0000;
      endcase
      a = a | ($urandom & 32'h003F_FFFF);
      if ($urandom_range(0, 7) == 0)
        cyc("R7 R9 mixed write", $urandom_range(0, 1) == 1, 1'($urandom), a,
            1'($urandom), 1'($urandom), 1'($urandom), 1,
            2'($urandom), 3'($urandom), 1'($urandom),
            $urandom | 32'h0000_0003);
      else
        cyc("R2 R3 R4 R5 mixed lookup", $urandom_range(0, 3) != 0,
            1'($urandom), a, 1'($urandom), $urandom_range(0, 3) != 0,
            $urandom_range(0, 3) != 0, 0, 0, 0, 0, 0);
    end
    cyc("R10 final idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    finish_run();
  end
endmodule